// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block joins a parameterised number of first-word-fall-through buffer stages in series, all on one common clock. Each stage passes its head word straight to the next stage's data input. Two active-low flags link each pair of neighbours. A stage pulls low its "output ready" flag when it holds a word. It pulls low its "input ready" flag when it has room. A word moves across a link in every cycle in which both flags on that link are low. No logic sits between the stages.

A word written into an empty chain ripples forward one stage per clock until it sits at the last stage's outputs. No read is needed to bring it there. The capacity of the chain is the sum of the stage depths. The chain's input-ready flag is the first stage's flag, and its output-ready flag is the last stage's flag. Users write on the front and read on the back, both with active-low enables, as they would with a single deeper buffer.

Top module: `fwft_chain`

## Requirements
- R1: After reset the chain is empty: `in_ready_n` is 0 and `out_ready_n` is 1.
- R2: With no reads, the chain accepts exactly STAGES*DEPTH words. After that, `in_ready_n` reads 1 until a word leaves.
- R3: A write (`wr_en_n`=0) presented while `in_ready_n` is 1 is ignored. No stage ever holds more than DEPTH words.
- R4: A read (`rd_en_n`=0) presented while `out_ready_n` is 1 is ignored and removes nothing. A read while `out_ready_n` is 0 removes the word shown on `rd_data`.
- R5: Words leave in the order they were accepted, each exactly once, with none lost.
- R6: A word written into an empty chain makes `out_ready_n` fall exactly STAGES clock edges after the accepting edge, counting that edge. No read is needed.
- R7: While `out_ready_n` is 0, `rd_data` shows the oldest word. It stays stable until a read is made.
- R8: A stage that holds words and whose successor is empty passes a word to the successor on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | WIDTH | Word to write |
| in_ready_n | output | 1 | Low when the first stage has room |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | WIDTH | Head word of the last stage |
| out_ready_n | output | 1 | Low when the last stage holds a word |

## Verification
On every cycle the assertions check that no stage overfills and that an empty stage with no incoming word stays empty. They also check that a waiting word crosses into an empty successor on the next edge, and that the presented output word holds steady until it is read. Only the bench scenarios can show end-to-end properties: the exact fall-through latency, the total capacity, the ordering of words across long mixed streams, and that writes into a full chain or reads from an empty one leave the word sequence untouched.

// File: rtl/fwft_chain.sv
module fwft_chain #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 3,
  parameter int DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [STAGES:0]            vld;
  logic [STAGES:0]            acc;
  logic [STAGES:0][WIDTH-1:0] dat;

  assign vld[0]      = ~wr_en_n;
  assign dat[0]      = wr_data;
  assign acc[STAGES] = ~rd_en_n;
  assign in_ready_n  = ~acc[0];
  assign out_ready_n = ~vld[STAGES];
  assign rd_data     = dat[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             push, pop;

    assign push = vld[s] & acc[s];
    assign pop  = vld[s+1] & acc[s+1];

    always_ff @(posedge clk)
      if (push) mem[wp] <= dat[s];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        if (push && !pop)      cnt <= cnt + 1'b1;
        else if (pop && !push) cnt <= cnt - 1'b1;
      end

    assign acc[s]   = (cnt != CW'(DEPTH));
    assign vld[s+1] = (cnt != '0);
    assign dat[s+1] = mem[rp];

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

    assert_empty_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !vld[s]) |=> (cnt == '0));

    if (s < STAGES - 1) begin : g_ripple
      assert_ripple_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && g_stage[s+1].cnt == '0) |=> (g_stage[s+1].cnt != '0));
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready_n && rd_en_n) |=> (!out_ready_n && $stable(rd_data)));
endmodule

// File: tb/fwft_chain_tb.sv
`timescale 1ns/1ps
module fwft_chain_tb;
  localparam int W = 16, N = 3, D = 4, CAP = N * D;

  logic clk = 0, rst_n = 0, wr_en_n = 1, rd_en_n = 1;
  logic [W-1:0] wr_data = '0, rd_data;
  logic in_ready_n, out_ready_n;
  int checks = 0, fails = 0, accepted = 0, reads = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] seq = 16'h100;

  always #4 clk = ~clk;

  fwft_chain #(.WIDTH(W), .STAGES(N), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .in_ready_n(in_ready_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .out_ready_n(out_ready_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && !wr_en_n && !in_ready_n) begin
    q.push_back(wr_data);
    accepted++;
  end

  always @(posedge clk) if (rst_n && !rd_en_n && !out_ready_n) begin
    reads++;
    if (q.size() == 0) check(0, "R4 read of phantom word", int'(rd_data), 0);
    else begin
      logic [W-1:0] e;
      e = q.pop_front();
      check(rd_data == e, "R5 order", int'(rd_data), int'(e));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check(in_ready_n == 0, "R1 in_ready_n", int'(in_ready_n), 0);
    check(out_ready_n == 1, "R1 out_ready_n", int'(out_ready_n), 1);
    rst_n = 1;
    @(negedge clk);

    // R6 latency and R7 fall-through presentation
    wr_data = 16'hBEEF; wr_en_n = 0;
    @(negedge clk); wr_en_n = 1;
    for (int j = 1; j <= N + 2; j++) begin
      check(out_ready_n == (j < N), "R6 latency", int'(out_ready_n), int'(j < N));
      @(negedge clk);
    end
    check(rd_data == 16'hBEEF, "R7 head word", int'(rd_data), 16'hBEEF);
    held = rd_data;
    repeat (3) @(negedge clk);
    check(rd_data == held && !out_ready_n, "R7 stable", int'(rd_data), int'(held));
    rd_en_n = 0; @(negedge clk); rd_en_n = 1;
    @(negedge clk);
    check(out_ready_n == 1, "R4 read removes word", int'(out_ready_n), 1);

    // R2 capacity and R3 writes while full ignored
    accepted = 0;
    for (int i = 0; i < CAP + 3 * N + 8; i++) begin
      wr_data = seq; wr_en_n = 0;
      @(negedge clk);
      if (q.size() != 0 && q[$] == seq) seq++;
    end
    wr_en_n = 1;
    check(accepted == CAP, "R2 capacity", accepted, CAP);
    check(in_ready_n == 1, "R2 full flag", int'(in_ready_n), 1);
    wr_data = 16'hDEAD; wr_en_n = 0;
    repeat (4) @(negedge clk);
    wr_en_n = 1;
    check(accepted == CAP, "R3 write while full ignored", accepted, CAP);

    // drain, then R4 reads on empty ignored
    reads = 0; rd_en_n = 0;
    repeat (CAP + 4 * N) @(negedge clk);
    check(reads == CAP, "R5 all words out once", reads, CAP);
    check(out_ready_n == 1, "R4 empty after drain", int'(out_ready_n), 1);
    repeat (5) @(negedge clk);
    check(reads == CAP, "R4 read on empty ignored", reads, CAP);
    rd_en_n = 1;
    wr_data = 16'h0A5A; wr_en_n = 0; @(negedge clk); wr_en_n = 1;
    repeat (N + 1) @(negedge clk);
    check(rd_data == 16'h0A5A, "R4 no stale word after empty reads", int'(rd_data), 16'h0A5A);
    rd_en_n = 0; @(negedge clk); rd_en_n = 1;

    // R5 mixed streaming with R8 ripple under back-pressure
    for (int i = 0; i < 400; i++) begin
      wr_data = seq; seq++;
      wr_en_n = ($urandom_range(0, 3) == 0);
      rd_en_n = ($urandom_range(0, 2) == 0);
      @(negedge clk);
    end
    wr_en_n = 1; rd_en_n = 0;
    repeat (CAP + 4 * N) @(negedge clk);
    rd_en_n = 1;
    check(q.size() == 0, "R5 nothing lost", q.size(), 0);
    check(out_ready_n == 1, "R8 chain drained", int'(out_ready_n), 1);
    finish_run();
  end
endmodule